// File: doc/BRIEF.md
# Iterated Halfword Integer Multiplier

This block forms the full 64-bit product of two 32-bit integers by running a single 16x16 multiplier array four times and summing the four partial products into a 64-bit accumulator. A one-cycle start pulse captures both operands and the operating mode. Four cycles later a one-cycle done pulse announces the product. The low 32 product bits appear on the result port and the upper 32 bits on a separate high-word port that a companion auxiliary register can load.

Two mode inputs select the operation. The first chooses between unsigned and two's-complement interpretation of the operands. The second selects a variant that also produces integer condition flags from the low result word. Signed products are formed from operand magnitudes, multiplied as unsigned values, and negated at the end when exactly one operand is negative. This keeps the shared array purely unsigned.

Top module: `iter_mul32`

## Requirements
- R1: During and after synchronous active-high reset, busy, done and flag_valid are 0, result_lo and result_hi are 0, and all four flags are 0.
- R2: With is_signed=0, {result_hi, result_lo} equals the unsigned 64-bit product of op_a and op_b.
- R3: With is_signed=1, {result_hi, result_lo} equals the 64-bit two's-complement product of op_a and op_b taken as signed values.
- R4: A start accepted at clock edge E sets busy after E. Busy stays high through edge E+3. Done is high for exactly one cycle after edge E+4, when busy returns to 0.
- R5: op_a, op_b, is_signed and set_cc are sampled only at the accepting edge. Changing them while busy does not alter the result or flags.
- R6: A start pulse while busy is ignored. The running operation completes on its original schedule with its original product.
- R7: When set_cc was 1 at acceptance, flag_valid pulses together with done, flag_n equals result_lo bit 31, flag_z is 1 exactly when result_lo is zero, and flag_v and flag_c are 0.
- R8: When set_cc was 0 at acceptance, flag_valid stays 0 and the four flag outputs keep their previous values.
- R9: The signed product of 0x80000000 by itself is 0x40000000_00000000 (result_hi=0x40000000, result_lo=0).
- R10: result_lo, result_hi and the flags hold their values from one done pulse until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply; ignored while busy |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| set_cc | input | 1 | 1: also produce condition flags |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: product valid |
| result_lo | output | 32 | Product bits 31:0 |
| result_hi | output | 32 | Product bits 63:32 |
| flag_valid | output | 1 | One-cycle pulse: flags updated |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (cleared) |
| flag_c | output | 1 | Carry flag (cleared) |

## Verification
Busy is due one edge after the accepting edge. Done, the product words and the flags are due exactly four edges after it, and they remain unchanged until the next done. The bench drives every input on the falling edge and samples on the following falling edges. It counts edges from the accepting one: it expects busy and no done after edges one to three and done after edge four. Operands and a second start are disturbed only between those samples, so each check sees the value owed at that exact edge.

// File: rtl/imul_pkg.sv
package imul_pkg;

    // Which halfword pair the shared array works on in each pass.
    typedef enum logic [1:0] {
        PASS_LL = 2'd0,
        PASS_LH = 2'd1,
        PASS_HL = 2'd2,
        PASS_HH = 2'd3
    } pass_e;

    // Operating mode captured at acceptance.
    typedef struct packed {
        logic sgn;
        logic upd_cc;
    } mode_t;

    // Integer condition flags.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    // Upper half of operand A is used in the two "H?" passes.
    function automatic logic use_hi_a(input pass_e p);
        return (p == PASS_HL) || (p == PASS_HH);
    endfunction

    // Upper half of operand B is used in the two "?H" passes.
    function automatic logic use_hi_b(input pass_e p);
        return (p == PASS_LH) || (p == PASS_HH);
    endfunction

endpackage

// File: rtl/imul_operand_prep.sv
module imul_operand_prep #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0] a_in,
    input  logic [OP_W-1:0] b_in,
    input  logic            sgn,
    output logic [OP_W-1:0] a_mag,
    output logic [OP_W-1:0] b_mag,
    output logic            negate
);
    localparam int MSB = OP_W - 1;

    logic a_neg;
    logic b_neg;

    assign a_neg = sgn & a_in[MSB];
    assign b_neg = sgn & b_in[MSB];

    // Magnitude as an unsigned value; the most negative input maps to 2^(OP_W-1).
    always_comb begin
        a_mag = a_neg ? (~a_in + {{(OP_W-1){1'b0}}, 1'b1}) : a_in;
        b_mag = b_neg ? (~b_in + {{(OP_W-1){1'b0}}, 1'b1}) : b_in;
    end

    assign negate = a_neg ^ b_neg;

    // R3: a non-negative input passes through untouched
    always_comb begin
        if (!a_neg) assert_mag_pass_R3: assert (a_mag == a_in);
    end

endmodule

// File: rtl/imul_half_array.sv
module imul_half_array #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0]   x,
    input  logic [HALF_W-1:0]   y,
    output logic [2*HALF_W-1:0] p
);
    localparam int PW = 2 * HALF_W;

    // Single unsigned array shared across all passes.
    assign p = PW'(x) * PW'(y);

endmodule

// File: rtl/imul_sequencer.sv
module imul_sequencer
    import imul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  accept,
    output logic  step,
    output logic  last,
    output pass_e pass,
    output logic  busy,
    output logic  done
);
    assign accept = start & ~busy;
    assign step   = busy;
    assign last   = busy & (pass == PASS_HH);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pass <= PASS_LL;
            done <= 1'b0;
        end else begin
            done <= last;
            if (accept) begin
                busy <= 1'b1;
                pass <= PASS_LL;
            end else if (busy) begin
                if (pass == PASS_HH) begin
                    busy <= 1'b0;
                    pass <= PASS_LL;
                end else begin
                    pass <= pass_e'(pass + 2'd1);
                end
            end
        end
    end

    // R4: busy persists until the final pass
    assert_busy_run_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && pass != PASS_HH) |=> busy);

    // R4: done follows the final pass and busy drops with it
    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && pass == PASS_HH) |=> (done && !busy));

    // R4: done is a single-cycle pulse
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a start during busy does not rewind the pass counter
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && start && pass != PASS_HH) |=> (pass != PASS_LL));

endmodule

// File: rtl/imul_accum.sv
module imul_accum
    import imul_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 step,
    input  pass_e                pass,
    input  logic [2*HALF_W-1:0]  pp,
    input  logic                 negate,
    output logic [4*HALF_W-1:0]  final_prod
);
    localparam int PP_W   = 2 * HALF_W;
    localparam int PROD_W = 4 * HALF_W;

    logic [PROD_W-1:0] acc;
    logic [PROD_W-1:0] pp_ext;
    logic [PROD_W-1:0] pp_aligned;
    logic [PROD_W-1:0] acc_sum;

    assign pp_ext = {{(PROD_W-PP_W){1'b0}}, pp};

    // Alignment: LL at 0, the two cross terms at one halfword, HH at two.
    always_comb begin
        unique case (pass)
            PASS_LL:          pp_aligned = pp_ext;
            PASS_LH, PASS_HL: pp_aligned = pp_ext << HALF_W;
            default:          pp_aligned = pp_ext << (2 * HALF_W);
        endcase
    end

    assign acc_sum    = acc + pp_aligned;
    assign final_prod = negate ? (~acc_sum + {{(PROD_W-1){1'b0}}, 1'b1}) : acc_sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (step) begin
            acc <= acc_sum;
        end
    end

    // R2: each operation starts from an empty accumulator
    assert_acc_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0));

endmodule

// File: rtl/imul_flag_gen.sv
module imul_flag_gen
    import imul_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [OP_W-1:0] low_word,
    output flags_t          flags,
    output logic            valid
);
    flags_t next_flags;

    always_comb begin
        next_flags   = FLAGS_CLEAR;
        next_flags.n = low_word[OP_W-1];
        next_flags.z = (low_word == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= FLAGS_CLEAR;
            valid <= 1'b0;
        end else begin
            valid <= load;
            if (load) flags <= next_flags;
        end
    end

    // R8: flags move only on a load
    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(flags));

endmodule

// File: rtl/iter_mul32.sv
module iter_mul32
    import imul_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2*HALF_W-1:0] op_a,
    input  logic [2*HALF_W-1:0] op_b,
    input  logic                is_signed,
    input  logic                set_cc,
    output logic                busy,
    output logic                done,
    output logic [2*HALF_W-1:0] result_lo,
    output logic [2*HALF_W-1:0] result_hi,
    output logic                flag_valid,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_v,
    output logic                flag_c
);
    localparam int OP_W   = 2 * HALF_W;
    localparam int PROD_W = 2 * OP_W;

    logic accept;
    logic step;
    logic last;
    pass_e pass;

    logic [OP_W-1:0]   a_mag;
    logic [OP_W-1:0]   b_mag;
    logic              neg_now;
    logic [OP_W-1:0]   a_mag_q;
    logic [OP_W-1:0]   b_mag_q;
    logic              neg_q;
    mode_t             mode_q;
    logic [HALF_W-1:0] x_half;
    logic [HALF_W-1:0] y_half;
    logic [OP_W-1:0]   pp;
    logic [PROD_W-1:0] final_prod;
    flags_t            flags;

    imul_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .step   (step),
        .last   (last),
        .pass   (pass),
        .busy   (busy),
        .done   (done)
    );

    imul_operand_prep #(.OP_W(OP_W)) u_prep (
        .a_in   (op_a),
        .b_in   (op_b),
        .sgn    (is_signed),
        .a_mag  (a_mag),
        .b_mag  (b_mag),
        .negate (neg_now)
    );

    // Operand and mode capture at the accepting edge only.
    always_ff @(posedge clk) begin
        if (rst) begin
            a_mag_q <= '0;
            b_mag_q <= '0;
            neg_q   <= 1'b0;
            mode_q  <= '{sgn: 1'b0, upd_cc: 1'b0};
        end else if (accept) begin
            a_mag_q <= a_mag;
            b_mag_q <= b_mag;
            neg_q   <= neg_now;
            mode_q  <= '{sgn: is_signed, upd_cc: set_cc};
        end
    end

    assign x_half = use_hi_a(pass) ? a_mag_q[OP_W-1:HALF_W] : a_mag_q[HALF_W-1:0];
    assign y_half = use_hi_b(pass) ? b_mag_q[OP_W-1:HALF_W] : b_mag_q[HALF_W-1:0];

    imul_half_array #(.HALF_W(HALF_W)) u_array (
        .x (x_half),
        .y (y_half),
        .p (pp)
    );

    imul_accum #(.HALF_W(HALF_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .step       (step),
        .pass       (pass),
        .pp         (pp),
        .negate     (neg_q),
        .final_prod (final_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_lo <= '0;
            result_hi <= '0;
        end else if (last) begin
            result_lo <= final_prod[OP_W-1:0];
            result_hi <= final_prod[PROD_W-1:OP_W];
        end
    end

    imul_flag_gen #(.OP_W(OP_W)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .load     (last & mode_q.upd_cc),
        .low_word (final_prod[OP_W-1:0]),
        .flags    (flags),
        .valid    (flag_valid)
    );

    assign flag_n = flags.n;
    assign flag_z = flags.z;
    assign flag_v = flags.v;
    assign flag_c = flags.c;

    // R10: the product words change only on the edge that ends an operation
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable({result_hi, result_lo}));

    // R7: published flags agree with the published low word
    assert_cc_track_R7: assert property (@(posedge clk) disable iff (rst)
        flag_valid |-> (done && flag_n == result_lo[OP_W-1]
                        && flag_z == (result_lo == '0)));

    // R8: no flag pulse without the flag-setting variant
    assert_no_cc_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q.upd_cc) |-> !flag_valid);

endmodule

// File: tb/tb_iter_mul32.sv
module tb_iter_mul32;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic        is_signed;
    logic        set_cc;
    logic        busy;
    logic        done;
    logic [31:0] result_lo;
    logic [31:0] result_hi;
    logic        flag_valid;
    logic        flag_n;
    logic        flag_z;
    logic        flag_v;
    logic        flag_c;

    int checks   = 0;
    int failures = 0;

    // Flag model, kept by the bench from the requirements.
    logic [3:0] exp_flags = 4'b0000;  // {n, z, v, c}

    always #4 clk = ~clk;  // 8 ns period, 125 MHz

    iter_mul32 dut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .is_signed(is_signed), .set_cc(set_cc), .busy(busy), .done(done),
        .result_lo(result_lo), .result_hi(result_hi), .flag_valid(flag_valid),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b,
                                             input logic sgn);
        logic [63:0] ax;
        logic [63:0] bx;
        ax = sgn ? {{32{a[31]}}, a} : {32'b0, a};
        bx = sgn ? {{32{b[31]}}, b} : {32'b0, b};
        return ax * bx;
    endfunction

    // disturb: 0 none, 1 change operands/mode while busy, 2 extra start while busy
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic sgn, input logic cc, input int disturb);
        logic [63:0] exp;
        exp = ref_prod(a, b, sgn);
        @(negedge clk);
        op_a = a; op_b = b; is_signed = sgn; set_cc = cc; start = 1'b1;
        @(negedge clk);  // accepting edge E passed
        start = 1'b0;
        chk("R4", "busy after accept", {63'b0, busy}, 64'd1);
        for (int i = 1; i <= 3; i++) begin
            if (disturb == 1) begin
                op_a = ~a; op_b = a ^ b ^ 32'h5A5A_0F0F; is_signed = ~sgn; set_cc = ~cc;
            end
            if (disturb == 2 && i == 1) start = 1'b1;
            @(negedge clk);  // edge E+i passed
            start = 1'b0;
            chk("R4", "busy/done mid run", {62'b0, busy, done}, 64'd2);
        end
        @(negedge clk);  // edge E+4 passed
        chk("R4", "done after four cycles", {62'b0, busy, done}, 64'd1);
        chk(req, "product", {result_hi, result_lo}, exp);
        if (cc) begin
            exp_flags = {exp[31], exp[31:0] == 32'h0, 1'b0, 1'b0};
            chk("R7", "flag_valid", {63'b0, flag_valid}, 64'd1);
            chk("R7", "flags nzvc", {60'b0, flag_n, flag_z, flag_v, flag_c}, {60'b0, exp_flags});
        end else begin
            chk("R8", "flag_valid", {63'b0, flag_valid}, 64'd0);
            chk("R8", "flags held", {60'b0, flag_n, flag_z, flag_v, flag_c}, {60'b0, exp_flags});
        end
        op_a = 32'h0; op_b = 32'h0;
    endtask

    task automatic test_reset();
        rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0; is_signed = 1'b0; set_cc = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "ctrl in reset", {61'b0, busy, done, flag_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "product after reset", {result_hi, result_lo}, 64'd0);
        chk("R1", "flags after reset", {60'b0, flag_n, flag_z, flag_v, flag_c}, 64'd0);
    endtask

    task automatic test_unsigned();
        run_op("R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 0);
        run_op("R2", 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b0, 0);
        run_op("R2", 32'h0000_0000, 32'hDEAD_BEEF, 1'b0, 1'b0, 0);
        run_op("R2", 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 0);
    endtask

    task automatic test_signed();
        run_op("R3", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 0);
        run_op("R3", 32'hFFFF_FFFD, 32'h0000_0005, 1'b1, 1'b0, 0);
        run_op("R3", 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b0, 0);
        run_op("R3", 32'h0001_2345, 32'hFFFE_0000, 1'b1, 1'b0, 0);
    endtask

    task automatic test_most_negative();
        run_op("R9", 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, 0);
        chk("R9", "high word", {32'b0, result_hi}, 64'h4000_0000);
        chk("R9", "low word", {32'b0, result_lo}, 64'h0);
    endtask

    task automatic test_latch_and_restart();
        run_op("R5", 32'hCAFE_1234, 32'h0BAD_F00D, 1'b1, 1'b1, 1);
        run_op("R6", 32'h0000_FFFF, 32'h0001_0001, 1'b0, 1'b0, 2);
        // R6: the stray start must not have begun a second operation
        @(negedge clk);
        chk("R6", "idle after run", {62'b0, busy, done}, 64'd0);
    endtask

    task automatic test_flags();
        run_op("R7", 32'hFFFF_FFFF, 32'h0000_0003, 1'b1, 1'b1, 0);  // negative low word
        run_op("R7", 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b1, 0);  // zero low, nonzero high
        chk("R7", "hi of 2^32", {32'b0, result_hi}, 64'd1);
        run_op("R8", 32'h0000_0002, 32'h0000_0003, 1'b0, 1'b0, 0);  // flags must stay
        run_op("R7", 32'h0000_0002, 32'h0000_0003, 1'b1, 1'b1, 0);  // positive nonzero
    endtask

    task automatic test_hold();
        logic [63:0] held;
        run_op("R2", 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0, 1'b1, 0);
        held = {result_hi, result_lo};
        op_a = 32'h1111_1111; op_b = 32'h2222_2222;
        repeat (5) @(negedge clk);
        chk("R10", "product held", {result_hi, result_lo}, held);
        chk("R10", "flags held", {60'b0, flag_n, flag_z, flag_v, flag_c}, {60'b0, exp_flags});
    endtask

    initial begin
        test_reset();
        test_unsigned();
        test_signed();
        test_most_negative();
        test_latch_and_restart();
        test_flags();
        test_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule